// File: doc/BRIEF.md
# Byte-Addressed SMBus Serial Memory

This block is a 256-byte memory that answers as one slave on an SMBus-style bus. It does not handle bus bits. A protocol decoder in front of it turns the wire activity into single-cycle events: a start condition with a 7-bit target address and a direction, a stop, a master-issued NACK, a byte written by the master, and a request for a byte to be returned to the master. The block decodes these events into the usual SMBus transactions: quick command, send byte, receive byte, a write that carries a command byte followed by data, and a combined write-then-read.

The block keeps a current-address pointer. The first byte of a write transaction is a command byte that gives a memory offset. The data bytes after it are stored from that offset upward, and they continue from offset 0 when they pass the top of the array. None of these transfers carries a length byte. A combined read takes its first byte from the command offset, and every byte after that comes from the advancing pointer. Several copies sit on one decoder, each at its own bus address. The returned data of all copies are ORed together, and this works because an idle copy drives zero.

Top module: `smbus_eeprom`

## Requirements
- R1: After reset the pointer is 0, the block is idle and `rd_valid` and `rd_byte` are 0.
- R2: Only a start whose address equals `DEV_ADDR` selects the block. While another address is selected, byte writes leave the memory unchanged and read requests get no response.
- R3: In a write transaction, the first byte is the command offset C. Data byte k (from 0) is stored at (C + k) mod 256, so a long write wraps from 255 to 0.
- R4: A write transaction with two or more bytes leaves the pointer unchanged.
- R5: A write transaction of exactly one byte followed by stop (send byte) loads the pointer with that byte.
- R6: A read start with no write before it (receive byte) returns the byte at the pointer and then advances the pointer by 1 mod 256.
- R7: In a combined read (write of command C, repeated start in the read direction), read k returns the byte at (C + k) mod 256. Afterwards the pointer holds C + n mod 256 after n reads.
- R8: `rd_valid` rises in the cycle after `rd_req` and lasts one cycle. `rd_byte` is 0 whenever `rd_valid` is low.
- R9: A quick command (a start in either direction followed directly by stop) changes neither the memory nor the pointer.
- R10: A read request that comes after the single receive byte, or after a NACK, answers 0x00 and leaves the pointer unchanged. Reads stay at 0x00 until the next stop.
- R11: A repeated start in the read direction directly after a write start with no bytes is an error. The reads that follow answer 0x00 and the pointer is kept.
- R12: A start to a different address abandons an open transaction. A single pending byte is then not taken as a send byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Start or repeated start event |
| ev_dir_rd | input | 1 | Direction of the start: 1 means master reads |
| ev_addr | input | 7 | Target address of the start |
| ev_stop | input | 1 | Stop event |
| ev_nack | input | 1 | Master NACKed the last byte it read |
| wr_valid | input | 1 | Master-to-slave byte strobe |
| wr_byte | input | 8 | Byte from the master |
| rd_req | input | 1 | Request for a slave-to-master byte |
| rd_valid | output | 1 | Response strobe, one cycle after `rd_req` |
| rd_byte | output | 8 | Returned byte, zero when `rd_valid` is low |

## Verification
A stale or corrupted pointer shows as a wrong byte on the first receive-byte transfer after the corruption, because that read is served straight from the pointer. A wrong transaction state shows one cycle after the next read request: either a data byte appears where 0x00 was due, or the reverse. A bad write offset or bad wrap stays hidden until that location is read back. For that reason the bench reads every offset of one copy and reads across the wrap point of every copy.

// File: rtl/eeprom_pkg.sv
// Shared definitions for the SMBus serial memory.
// Assumes: one decoder event per cycle at most.
package eeprom_pkg;
    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_WRITE = 3'd1,
        M_RECV  = 3'd2,
        M_READ  = 3'd3,
        M_DONE  = 3'd4,
        M_ERR   = 3'd5
    } mode_t;
endpackage

// File: rtl/eeprom_array.sv
// Byte storage with one write port and one registered read port.
// Assumes: contents are not reset; the read and write addresses are never equal in the same cycle.
module eeprom_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Store one byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Capture the addressed byte on a read strobe.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/eeprom_seq.sv
// Transaction sequencer: tracks selection, transfer mode, the command
// offset, the write offset and the current pointer, and steers the array ports.
// Assumes: AW <= 8; at most one event per cycle (start > stop > nack > write > read if several).
module eeprom_seq
    import eeprom_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic          ev_dir_rd,
    input  logic [6:0]    ev_addr,
    input  logic          ev_stop,
    input  logic          ev_nack,
    input  logic          wr_valid,
    input  logic [7:0]    wr_byte,
    input  logic          rd_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic          rd_fire,
    output logic          rd_err,
    output logic [AW-1:0] rd_addr,
    output mode_t         mode_o,
    output logic          sel_o,
    output logic [AW-1:0] ptr_o
);
    mode_t         mode;
    logic          sel;
    logic [1:0]    nbytes;
    logic [AW-1:0] cmd;
    logic [AW-1:0] woff;
    logic [AW-1:0] ptr;
    logic          first;
    logic          hit;
    logic          quiet;
    logic          wr_go;
    logic          rd_ok;

    // Decode which event acts this cycle and where a read is served from.
    always_comb begin
        hit       = ev_start && (ev_addr == DEV_ADDR);
        quiet     = !(ev_start || ev_stop || ev_nack);
        wr_go     = quiet && wr_valid && sel;
        rd_fire   = quiet && !wr_valid && rd_req && sel;
        rd_ok     = (mode == M_RECV) || (mode == M_READ);
        rd_err    = rd_fire && !rd_ok;
        rd_addr   = (mode == M_READ && first) ? cmd : ptr;
        mem_we    = wr_go && (mode == M_WRITE) && (nbytes != 2'd0);
        mem_waddr = woff;
        mem_wdata = wr_byte;
        mode_o    = mode;
        sel_o     = sel;
        ptr_o     = ptr;
    end

    // Advance the transaction state on each decoder event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= M_IDLE;
            sel    <= 1'b0;
            nbytes <= 2'd0;
            cmd    <= '0;
            woff   <= '0;
            ptr    <= '0;
            first  <= 1'b0;
        end else if (ev_start) begin
            if (hit) begin
                sel <= 1'b1;
                if (!ev_dir_rd) begin
                    mode   <= (mode == M_IDLE) ? M_WRITE : M_ERR;
                    nbytes <= 2'd0;
                end else begin
                    case (mode)
                        M_IDLE:  mode <= M_RECV;
                        M_WRITE: begin
                            if (nbytes == 2'd0) begin
                                mode <= M_ERR;
                            end else begin
                                mode  <= M_READ;
                                first <= 1'b1;
                            end
                        end
                        default: mode <= M_ERR;
                    endcase
                end
            end else begin
                sel    <= 1'b0;
                mode   <= M_IDLE;
                nbytes <= 2'd0;
                first  <= 1'b0;
            end
        end else if (ev_stop) begin
            if (sel && mode == M_WRITE && nbytes == 2'd1) ptr <= cmd;
            sel    <= 1'b0;
            mode   <= M_IDLE;
            nbytes <= 2'd0;
            first  <= 1'b0;
        end else if (ev_nack) begin
            if (sel) mode <= (mode == M_READ || mode == M_DONE) ? M_DONE : M_ERR;
        end else if (wr_go) begin
            if (mode == M_WRITE) begin
                if (nbytes == 2'd0) begin
                    cmd  <= wr_byte[AW-1:0];
                    woff <= wr_byte[AW-1:0];
                end else begin
                    woff <= woff + AW'(1);
                end
                if (nbytes != 2'd2) nbytes <= nbytes + 2'd1;
            end
        end else if (rd_fire) begin
            case (mode)
                M_RECV: begin
                    ptr  <= rd_addr + AW'(1);
                    mode <= M_DONE;
                end
                M_READ: begin
                    ptr   <= rd_addr + AW'(1);
                    first <= 1'b0;
                end
                default: mode <= M_ERR;
            endcase
        end
    end
endmodule

// File: rtl/smbus_eeprom.sv
// SMBus serial memory slave: sequencer plus byte array plus a one-cycle
// response stage whose data output is zero when idle, so copies can be ORed.
// Assumes: the decoder gives at most one event per cycle.
module smbus_eeprom
    import eeprom_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_dir_rd,
    input  logic [6:0] ev_addr,
    input  logic       ev_stop,
    input  logic       ev_nack,
    input  logic       wr_valid,
    input  logic [7:0] wr_byte,
    input  logic       rd_req,
    output logic       rd_valid,
    output logic [7:0] rd_byte
);
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;
    logic          rd_fire;
    logic          rd_err;
    logic [AW-1:0] rd_addr;
    mode_t         mode_w;
    logic          sel_w;
    logic [AW-1:0] ptr_w;
    logic [7:0]    q;
    logic          rsp_valid;
    logic          rsp_err;

    eeprom_seq #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev_start), .ev_dir_rd(ev_dir_rd), .ev_addr(ev_addr),
        .ev_stop(ev_stop), .ev_nack(ev_nack),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .rd_fire(rd_fire), .rd_err(rd_err), .rd_addr(rd_addr),
        .mode_o(mode_w), .sel_o(sel_w), .ptr_o(ptr_w)
    );

    eeprom_array #(.AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(rd_fire && !rd_err), .raddr(rd_addr), .rdata(q)
    );

    // Register the response strobe and whether it must answer zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= rd_fire;
            rsp_err   <= rd_err;
        end
    end

    // Drive data only while responding, zero otherwise.
    always_comb begin
        rd_valid = rsp_valid;
        rd_byte  = (rsp_valid && !rsp_err) ? q : 8'h00;
    end
endmodule

// File: rtl/eeprom_checks.sv
// Property checker for smbus_eeprom, attached by bind below.
// Assumes: one decoder event per cycle.
module eeprom_checks
    import eeprom_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_start,
    input logic          ev_stop,
    input logic          ev_nack,
    input logic          wr_valid,
    input logic          rd_req,
    input logic          rd_valid,
    input logic [7:0]    rd_byte,
    input mode_t         mode,
    input logic          sel,
    input logic [AW-1:0] ptr
);
    logic calm;
    always_comb calm = !(ev_start || ev_stop || ev_nack);

    a_r8_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_byte == 8'h00);

    a_r4_write_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (calm && wr_valid) |=> $stable(ptr));

    a_r6_recv_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (calm && !wr_valid && rd_req && sel && mode == M_RECV)
        |=> (ptr == $past(ptr) + AW'(1)) && mode == M_DONE);

    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (mode == M_IDLE) && !sel);

    a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (calm && !wr_valid && rd_req && sel && (mode == M_DONE || mode == M_ERR))
        |=> rd_valid && rd_byte == 8'h00 && $stable(ptr));
endmodule

bind smbus_eeprom eeprom_checks #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_nack(ev_nack), .wr_valid(wr_valid), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .mode(mode_w), .sel(sel_w), .ptr(ptr_w)
);

// File: tb/tb_smbus_eeprom.sv
module tb_smbus_eeprom;
    localparam int NDEV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 0, ev_dir_rd = 0, ev_stop = 0, ev_nack = 0;
    logic [6:0] ev_addr = 0;
    logic       wr_valid = 0, rd_req = 0;
    logic [7:0] wr_byte = 0;
    logic [NDEV-1:0] vld;
    logic [7:0] byt [NDEV];
    logic [7:0] byte_or;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] mdl [NDEV][256];
    int mptr [NDEV];

    always #10 clk = ~clk;

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        smbus_eeprom #(.AW(8), .DEV_ADDR(7'(7'h50 + g))) dut (
            .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_dir_rd(ev_dir_rd),
            .ev_addr(ev_addr), .ev_stop(ev_stop), .ev_nack(ev_nack),
            .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
            .rd_valid(vld[g]), .rd_byte(byt[g])
        );
    end

    always_comb begin
        byte_or = 8'h00;
        for (int i = 0; i < NDEV; i++) byte_or = byte_or | byt[i];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick; @(negedge clk); endtask

    task automatic op_start(input logic [6:0] a, input bit rd);
        ev_start = 1; ev_addr = a; ev_dir_rd = rd; tick; ev_start = 0;
    endtask
    task automatic op_stop; ev_stop = 1; tick; ev_stop = 0; endtask
    task automatic op_nack; ev_nack = 1; tick; ev_nack = 0; endtask
    task automatic op_send(input logic [7:0] b);
        wr_valid = 1; wr_byte = b; tick; wr_valid = 0;
    endtask
    // Request a byte; response is sampled one cycle later (R8).
    task automatic op_recv(input int dev, input logic [7:0] exp, input string req);
        logic [NDEV-1:0] ev;
        ev = (dev < 0) ? '0 : NDEV'(1) << dev;
        rd_req = 1; tick;
        chk(vld == ev, {req, " R8 strobe"}, int'(vld), int'(ev));
        chk(byte_or == exp, req, int'(byte_or), int'(exp));
        rd_req = 0;
    endtask

    function automatic logic [7:0] pat(input int d, input int k, input int s);
        return 8'((d * 37 + k * 11 + s * 29 + 5) & 255);
    endfunction

    // Write transaction: command then n data bytes (n=0 is a send byte).
    task automatic page_write(input int d, input int c, input int n, input int s);
        op_start(7'(8'h50 + d), 0);
        op_send(8'(c));
        for (int k = 0; k < n; k++) begin
            op_send(pat(d, k, s));
            mdl[d][(c + k) & 255] = pat(d, k, s);
        end
        op_stop;
        if (n == 0) mptr[d] = c;
    endtask

    task automatic comb_read(input int d, input int c, input int n, input string req);
        op_start(7'(8'h50 + d), 0);
        op_send(8'(c));
        op_start(7'(8'h50 + d), 1);
        for (int k = 0; k < n; k++) op_recv(d, mdl[d][(c + k) & 255], req);
        op_nack;
        op_stop;
        mptr[d] = (c + n) & 255;
    endtask

    task automatic recv_byte(input int d, input string req);
        op_start(7'(8'h50 + d), 1);
        op_recv(d, mdl[d][mptr[d]], req);
        mptr[d] = (mptr[d] + 1) & 255;
        op_nack;
        op_stop;
    endtask

    initial begin
        for (int d = 0; d < NDEV; d++) mptr[d] = 0;
        repeat (3) tick;
        chk(vld == '0, "R1 valid after reset", int'(vld), 0);
        chk(byte_or == 8'h00, "R1 byte after reset", int'(byte_or), 0);
        rst_n = 1; tick;

        // Fill each copy with a wrapping 256-byte write (R3, R4).
        for (int d = 0; d < NDEV; d++) page_write(d, 8'hF0 + d, 256, 0);
        for (int d = 0; d < NDEV; d++) recv_byte(d, "R1 pointer starts at 0 / R4");

        // Every offset of copy 0 through a combined read (R7, R3).
        for (int off = 0; off < 256; off++) comb_read(0, off, 1, "R7 single offset R3");
        for (int d = 0; d < NDEV; d++) comb_read(d, 8'hFC, 8, "R7 sequential wrap");
        for (int d = 0; d < NDEV; d++) recv_byte(d, "R7 pointer after read");

        // Send byte sets pointer, receive byte advances and wraps (R5, R6).
        for (int d = 0; d < NDEV; d++) begin
            page_write(d, 8'h80 + d, 0, 0);
            repeat (3) recv_byte(d, "R5 R6 pointer load and advance");
            page_write(d, 8'hFF, 0, 0);
            repeat (2) recv_byte(d, "R6 pointer wrap");
        end

        // Short wrapping write, pointer kept across writes (R3, R4).
        page_write(3, 8'hFE, 4, 1);
        comb_read(3, 8'hFE, 4, "R3 short wrap");
        page_write(3, 8'h40, 3, 2);
        recv_byte(3, "R4 write keeps pointer");

        // Quick commands (R9).
        op_start(7'h52, 0); op_stop;
        op_start(7'h52, 1); op_stop;
        recv_byte(2, "R9 quick command");
        comb_read(2, 8'h10, 2, "R9 memory intact");

        // Foreign address (R2).
        op_start(7'h20, 0); op_send(8'h10); op_send(8'hAA); op_send(8'hBB); op_stop;
        op_start(7'h20, 1); op_recv(-1, 8'h00, "R2 no response"); op_stop;
        comb_read(0, 8'h10, 4, "R2 memory unchanged");

        // Read beyond receive byte and after NACK (R10).
        op_start(7'h51, 1);
        op_recv(1, mdl[1][mptr[1]], "R10 first receive");
        mptr[1] = (mptr[1] + 1) & 255;
        op_recv(1, 8'h00, "R10 extra receive");
        op_recv(1, 8'h00, "R10 stays zero");
        op_stop;
        recv_byte(1, "R10 pointer kept");
        op_start(7'h51, 0); op_send(8'h33); op_start(7'h51, 1);
        op_recv(1, mdl[1][8'h33], "R10 read before nack");
        op_nack;
        op_recv(1, 8'h00, "R10 read after nack");
        op_stop;
        mptr[1] = 8'h34;
        recv_byte(1, "R10 pointer after nack");

        // Read start after empty write start (R11).
        op_start(7'h56, 0); op_start(7'h56, 1);
        op_recv(6, 8'h00, "R11 error read");
        op_stop;
        recv_byte(6, "R11 pointer kept");

        // Abandoned single byte is not a send byte (R12).
        op_start(7'h54, 0); op_send(8'h99); op_start(7'h20, 0); op_stop;
        recv_byte(4, "R12 abort");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule